// File: doc/BRIEF.md
# Hot-Plug Slot Control Register

This block is the slot control register of a hot-plug capable serial-link port, together with the logic it drives. Software programs event enables and two indicator fields through a small read/write port. A write to an indicator field updates the indicator state that reads return, and sends one message to the slot hardware through a valid/ready output. Each finished message counts as a completed command.

Three slot events are tracked: link-active change, command completion and presence-detect change. Each event sets a sticky status bit, held at a second address and cleared by writing 1. A single hot-plug interrupt is raised while an enabled status bit is set and the master enable is on. While the port sits in a low-power state, an enabled presence-detect change raises a wake request instead of the interrupt.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset both registers read 0x0000 and no interrupt, wake request or message is active. At address 0, bits 15:13, 11 and 10 always read zero and ignore writes.
- R2: Control bits 2, 1 and 0 are plain read/write storage and never cause an interrupt.
- R3: Indicator fields are bits 9:8 (power, message kind 0) and 7:6 (attention, message kind 1), coded 01 on, 10 blink, 11 off. A write of a non-zero code updates the read-back value and sends exactly one message carrying that code, even when the code equals the current state.
- R4: A write of code 00 to an indicator field sends no message and leaves that field's read-back value unchanged. A presented message never carries code 00.
- R5: When one write changes both indicator fields, the power message is presented before the attention message.
- R6: While msg_valid is high and msg_ready is low, msg_valid, msg_kind and msg_state hold their values.
- R7: Each completed message handshake sets status bit 1 (command completed). With control bits 4 and 5 set, this raises hp_irq.
- R8: A pulse on ev_link_chg sets status bit 0. With control bits 12 and 5 set, this raises hp_irq.
- R9: A pulse on ev_pres_chg sets status bit 2. With control bit 3 set, this raises hp_irq (bit 5 also set) when low_power is low. When low_power is high, it raises wake_req and not hp_irq.
- R10: With control bit 5 clear, hp_irq stays low whatever the status and the other enables.
- R11: Writing 1 to a status bit at address 1 clears it. An event arriving on the same clock edge as the clearing write wins, and the bit stays set.
- R12: hp_irq and wake_req are registered. They follow the status and enable state one clock after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = event status register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| ev_link_chg | input | 1 | One-cycle pulse on a link-active state change |
| ev_pres_chg | input | 1 | One-cycle pulse on a presence-detect state change |
| low_power | input | 1 | Port is in a low-power state |
| msg_valid | output | 1 | Indicator message is presented |
| msg_ready | input | 1 | Message transport accepts the message |
| msg_kind | output | 1 | 0 = power indicator, 1 = attention indicator |
| msg_state | output | 2 | Indicator code carried by the message |
| hp_irq | output | 1 | Hot-plug interrupt |
| wake_req | output | 1 | Wake request |

## Verification
The hardest situations to reach are a status bit being cleared and set on the same clock edge, and an indicator message stalled under backpressure while the command-completed path waits on it. The bench lines up a clearing write and an event pulse on the same edge. It also holds msg_ready low across several cycles after an indicator write before releasing it, and then watches the interrupt appear one cycle after the handshake completes.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W  = 16;
  localparam int CODE_W = 2;
  localparam int N_IND  = 2;
  localparam int N_EVT  = 3;

  // control register bit positions
  localparam int B_LINK_EN = 12;
  localparam int PWR_LO    = 8;
  localparam int ATT_LO    = 6;
  localparam int B_MASTER  = 5;
  localparam int B_CC_EN   = 4;
  localparam int B_PRES_EN = 3;
  localparam int SPARE_W   = 3;

  // status register bit positions
  localparam int S_LINK = 0;
  localparam int S_CC   = 1;
  localparam int S_PRES = 2;

  typedef enum logic [CODE_W-1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_code_e;

  localparam int IDX_PWR = 0;
  localparam int IDX_ATT = 1;
endpackage

// File: rtl/hp_ind_msg_queue.sv
module hp_ind_msg_queue #(
  parameter int N_IND  = 2,
  parameter int CODE_W = 2,
  localparam int SEL_W = (N_IND > 1) ? $clog2(N_IND) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IND-1:0]        set_vec,
  input  logic [N_IND*CODE_W-1:0] code_in,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [SEL_W-1:0]        out_sel,
  output logic [CODE_W-1:0]       out_code,
  output logic                    done
);
  logic [N_IND-1:0]  pend;
  logic [N_IND-1:0]  take;
  logic [CODE_W-1:0] code_q [N_IND];
  logic              load;
  logic              found;
  logic [SEL_W-1:0]  pick_sel;
  logic [CODE_W-1:0] pick_code;

  assign load = !out_valid || out_ready;
  assign done = out_valid && out_ready;

  // lowest index wins: slot 0 (power) goes out before slot 1 (attention)
  always_comb begin
    take      = '0;
    found     = 1'b0;
    pick_sel  = '0;
    pick_code = '0;
    for (int i = 0; i < N_IND; i++) begin
      if (pend[i] && !found) begin
        found     = 1'b1;
        take[i]   = load;
        pick_sel  = SEL_W'(i);
        pick_code = code_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      for (int i = 0; i < N_IND; i++) code_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_IND; i++) begin
        if (set_vec[i]) begin
          pend[i]   <= 1'b1;
          code_q[i] <= code_in[i*CODE_W +: CODE_W];
        end else if (take[i]) begin
          pend[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sel   <= '0;
      out_code  <= '0;
    end else if (load) begin
      out_valid <= found;
      if (found) begin
        out_sel  <= pick_sel;
        out_code <= pick_code;
      end
    end
  end
endmodule

// File: rtl/hp_evt_status.sv
module hp_evt_status #(
  parameter int N_EVT    = 3,
  parameter int WAKE_IDX = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_set,
  input  logic [N_EVT-1:0] evt_clr,
  input  logic [N_EVT-1:0] evt_en,
  input  logic             master_en,
  input  logic             low_power,
  output logic [N_EVT-1:0] sts,
  output logic             irq_q,
  output logic             wake_q
);
  logic [N_EVT-1:0] irq_terms;

  always_comb begin
    irq_terms = sts & evt_en;
    if (low_power) irq_terms[WAKE_IDX] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts    <= '0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      for (int i = 0; i < N_EVT; i++) begin
        if (evt_set[i])      sts[i] <= 1'b1;
        else if (evt_clr[i]) sts[i] <= 1'b0;
      end
      irq_q  <= master_en && (|irq_terms);
      wake_q <= low_power && sts[WAKE_IDX] && evt_en[WAKE_IDX];
    end
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ev_link_chg,
  input  logic        ev_pres_chg,
  input  logic        low_power,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic        msg_kind,
  output logic [1:0]  msg_state,
  output logic        hp_irq,
  output logic        wake_req
);
  logic               ctl_link_en;
  logic               ctl_master;
  logic               ctl_cc_en;
  logic               ctl_pres_en;
  logic [SPARE_W-1:0] ctl_spare;
  logic [CODE_W-1:0]  pwr_q;
  logic [CODE_W-1:0]  att_q;

  logic               wr_ctl;
  logic               wr_sts;
  logic [CODE_W-1:0]  wr_pwr;
  logic [CODE_W-1:0]  wr_att;
  logic [N_IND-1:0]   ind_set;
  logic [N_IND*CODE_W-1:0] ind_codes;
  logic               cmd_done;
  logic [N_EVT-1:0]   evt_set;
  logic [N_EVT-1:0]   evt_clr;
  logic [N_EVT-1:0]   evt_en;
  logic [N_EVT-1:0]   sts;

  assign wr_ctl = reg_wr && !reg_addr;
  assign wr_sts = reg_wr &&  reg_addr;
  assign wr_pwr = reg_wdata[PWR_LO +: CODE_W];
  assign wr_att = reg_wdata[ATT_LO +: CODE_W];

  always_comb begin
    ind_set          = '0;
    ind_set[IDX_PWR] = wr_ctl && (wr_pwr != IND_RSVD);
    ind_set[IDX_ATT] = wr_ctl && (wr_att != IND_RSVD);
    ind_codes        = '0;
    ind_codes[IDX_PWR*CODE_W +: CODE_W] = wr_pwr;
    ind_codes[IDX_ATT*CODE_W +: CODE_W] = wr_att;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_link_en <= 1'b0;
      ctl_master  <= 1'b0;
      ctl_cc_en   <= 1'b0;
      ctl_pres_en <= 1'b0;
      ctl_spare   <= '0;
      pwr_q       <= IND_RSVD;
      att_q       <= IND_RSVD;
    end else if (wr_ctl) begin
      ctl_link_en <= reg_wdata[B_LINK_EN];
      ctl_master  <= reg_wdata[B_MASTER];
      ctl_cc_en   <= reg_wdata[B_CC_EN];
      ctl_pres_en <= reg_wdata[B_PRES_EN];
      ctl_spare   <= reg_wdata[SPARE_W-1:0];
      if (ind_set[IDX_PWR]) pwr_q <= wr_pwr;
      if (ind_set[IDX_ATT]) att_q <= wr_att;
    end
  end

  hp_ind_msg_queue #(
    .N_IND  (N_IND),
    .CODE_W (CODE_W)
  ) queue_i (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (ind_set),
    .code_in   (ind_codes),
    .out_valid (msg_valid),
    .out_ready (msg_ready),
    .out_sel   (msg_kind),
    .out_code  (msg_state),
    .done      (cmd_done)
  );

  always_comb begin
    evt_set         = '0;
    evt_set[S_LINK] = ev_link_chg;
    evt_set[S_CC]   = cmd_done;
    evt_set[S_PRES] = ev_pres_chg;
    evt_en          = '0;
    evt_en[S_LINK]  = ctl_link_en;
    evt_en[S_CC]    = ctl_cc_en;
    evt_en[S_PRES]  = ctl_pres_en;
    evt_clr         = wr_sts ? reg_wdata[N_EVT-1:0] : '0;
  end

  hp_evt_status #(
    .N_EVT    (N_EVT),
    .WAKE_IDX (S_PRES)
  ) status_i (
    .clk       (clk),
    .rst       (rst),
    .evt_set   (evt_set),
    .evt_clr   (evt_clr),
    .evt_en    (evt_en),
    .master_en (ctl_master),
    .low_power (low_power),
    .sts       (sts),
    .irq_q     (hp_irq),
    .wake_q    (wake_req)
  );

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr) begin
      reg_rdata[B_LINK_EN]             = ctl_link_en;
      reg_rdata[PWR_LO +: CODE_W]      = pwr_q;
      reg_rdata[ATT_LO +: CODE_W]      = att_q;
      reg_rdata[B_MASTER]              = ctl_master;
      reg_rdata[B_CC_EN]               = ctl_cc_en;
      reg_rdata[B_PRES_EN]             = ctl_pres_en;
      reg_rdata[SPARE_W-1:0]           = ctl_spare;
    end else begin
      reg_rdata[N_EVT-1:0] = sts;
    end
  end
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_addr,
  input logic [15:0] reg_rdata,
  input logic        master,
  input logic        low_power,
  input logic        hp_irq,
  input logic        wake_req,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic        msg_kind,
  input logic [1:0]  msg_state
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !reg_addr |-> (reg_rdata[15:13] == 3'b000 && reg_rdata[11:10] == 2'b00));

  assert_no_rsvd_code_R4: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> msg_state != 2'b00);

  assert_msg_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_state)));

  assert_master_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(master)) |-> !hp_irq);

  assert_wake_lp_R9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && wake_req) |-> $past(low_power));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .master    (ctl_master),
  .low_power (low_power),
  .hp_irq    (hp_irq),
  .wake_req  (wake_req),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_kind  (msg_kind),
  .msg_state (msg_state)
);

// File: tb/hp_slot_ctrl_tb_top.sv
module hp_slot_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ev_link_chg = 1'b0;
  logic        ev_pres_chg = 1'b0;
  logic        low_power = 1'b0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic        msg_kind;
  logic [1:0]  msg_state;
  logic        hp_irq;
  logic        wake_req;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int       n_msg = 0;
  logic     cap_kind  [32];
  logic [1:0] cap_state [32];

  always #4 clk = ~clk;

  hp_slot_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_link_chg(ev_link_chg), .ev_pres_chg(ev_pres_chg), .low_power(low_power),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_state(msg_state), .hp_irq(hp_irq), .wake_req(wake_req)
  );

  always @(posedge clk) begin
    if (!rst && msg_valid && msg_ready && n_msg < 32) begin
      cap_kind[n_msg]  <= msg_kind;
      cap_state[n_msg] <= msg_state;
      n_msg <= n_msg + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_link();
    @(negedge clk); ev_link_chg = 1'b1;
    @(negedge clk); ev_link_chg = 1'b0;
  endtask

  task automatic pulse_pres();
    @(negedge clk); ev_pres_chg = 1'b1;
    @(negedge clk); ev_pres_chg = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(1'b0, d); check("R1 ctl after reset", d, 16'h0000);
    rd(1'b1, d); check("R1 status after reset", d, 16'h0000);
    check("R1 outputs after reset", {hp_irq, wake_req, msg_valid}, 3'b000);
  endtask

  task automatic t_all_ones();
    logic [15:0] d;
    int base;
    base = n_msg;
    wr(1'b0, 16'hFFFF);
    idle(6);
    rd(1'b0, d); check("R1 reserved bits ignore writes", d, 16'h13FF);
    check("R5 two messages sent", n_msg - base, 2);
    check("R5 power message first", {cap_kind[base], cap_state[base]}, 3'b011);
    check("R5 attention message second", {cap_kind[base+1], cap_state[base+1]}, 3'b111);
    base = n_msg;
    wr(1'b0, 16'h0000);
    idle(5);
    rd(1'b0, d); check("R4 code 00 keeps indicator state", d, 16'h03C0);
    check("R4 code 00 sends no message", n_msg - base, 0);
    wr(1'b1, 16'h0007);
    idle(2);
  endtask

  task automatic t_storage();
    logic [15:0] d;
    wr(1'b0, 16'h0027);
    pulse_link();
    pulse_pres();
    idle(3);
    check("R2 spare bits cause no interrupt", hp_irq, 1'b0);
    rd(1'b0, d); check("R2 spare bits read back", d & 16'h0007, 16'h0007);
    rd(1'b1, d); check("R8 R9 status set without enables", d, 16'h0005);
    wr(1'b1, 16'h0007);
    idle(2);
  endtask

  task automatic t_link();
    logic [15:0] d;
    wr(1'b0, 16'h1020);
    pulse_link();
    check("R12 irq lags status by one cycle", hp_irq, 1'b0);
    idle(1);
    check("R8 link change raises irq", hp_irq, 1'b1);
    rd(1'b1, d); check("R8 link status bit 0", d, 16'h0001);
    wr(1'b1, 16'h0001);
    idle(1);
    check("R11 write 1 clears status and irq", hp_irq, 1'b0);
    rd(1'b1, d); check("R11 status cleared", d, 16'h0000);
  endtask

  task automatic t_master();
    logic [15:0] d;
    wr(1'b0, 16'h1000);
    pulse_link();
    idle(3);
    check("R10 no irq with master off", hp_irq, 1'b0);
    rd(1'b1, d); check("R10 status still recorded", d, 16'h0001);
    wr(1'b0, 16'h1020);
    idle(1);
    check("R10 irq once master set", hp_irq, 1'b1);
    wr(1'b1, 16'h0001);
    idle(2);
  endtask

  task automatic t_cmd();
    logic [15:0] d;
    int base;
    base = n_msg;
    msg_ready = 1'b0;
    wr(1'b0, 16'h0130);
    idle(4);
    check("R6 message held under backpressure", {msg_valid, msg_kind, msg_state}, 4'b1001);
    check("R7 no completion before handshake", hp_irq, 1'b0);
    rd(1'b0, d); check("R3 power indicator reads on", d[9:8], 2'b01);
    @(negedge clk); msg_ready = 1'b1;
    idle(2);
    check("R7 completion raises irq", hp_irq, 1'b1);
    rd(1'b1, d); check("R7 command completed status", d, 16'h0002);
    wr(1'b1, 16'h0002);
    wr(1'b0, 16'h0130);
    idle(5);
    check("R3 same-value write sends again", n_msg - base, 2);
    check("R3 repeated message code", {cap_kind[base+1], cap_state[base+1]}, 3'b001);
    wr(1'b0, 16'h0080);
    idle(5);
    check("R3 attention blink message", {cap_kind[base+2], cap_state[base+2]}, 3'b110);
    rd(1'b0, d); check("R3 read-back after attention write", d, 16'h0180);
    wr(1'b1, 16'h0007);
    idle(2);
  endtask

  task automatic t_pres();
    logic [15:0] d;
    wr(1'b0, 16'h0028);
    pulse_pres();
    idle(1);
    check("R9 presence irq when awake", {hp_irq, wake_req}, 2'b10);
    wr(1'b1, 16'h0004);
    idle(2);
    low_power = 1'b1;
    pulse_pres();
    idle(1);
    check("R9 presence wake in low power", {hp_irq, wake_req}, 2'b01);
    wr(1'b1, 16'h0004);
    idle(2);
    check("R9 wake drops after clear", wake_req, 1'b0);
    low_power = 1'b0;
    rd(1'b1, d); check("R9 status cleared", d, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    @(negedge clk);
    reg_addr = 1'b1; reg_wdata = 16'h0001; reg_wr = 1'b1; ev_link_chg = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_link_chg = 1'b0;
    rd(1'b1, d); check("R11 event beats same-edge clear", d, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_all_ones();
    t_storage();
    t_link();
    t_master();
    t_cmd();
    t_pres();
    t_set_wins();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule